// File: doc/BRIEF.md
# T1 Framing Bit Error Injector

This block sits on the framing-bit output of a T1 transmit framer and inverts chosen framing-pattern bits so that a test setup can judge how the far-end receiver copes with framing errors. Each framing-bit slot reaches the block as a bit, a valid strobe and two slot markers. One marker flags terminal-framing bits of the 12-frame superframe (odd frames). The other flags frame-pattern-sequence bits of the 24-frame extended superframe (every fourth frame). A mode input picks which marker decides whether a bit may be corrupted. Only those bits, called candidates below, are ever touched.

Two independent controls drive the injection. The periodic control, while it is held high, inverts one candidate out of every 128. The burst control acts on its rising edge: it inverts the next three candidates, which is enough to push the remote receiver out of frame alignment. The output is the framing bit after this treatment, registered, together with a delayed copy of the valid strobe.

Top module: `t1_fbit_corruptor`

## Requirements
- R1: A slot is a candidate only when fbit_valid_i is 1 and the selected marker is 1. The marker is ft_slot_i when esf_mode_i is 0 and fps_slot_i when esf_mode_i is 1. A slot that is not a candidate leaves the block unchanged.
- R2: fbit_o and fbit_valid_o are registered. They carry the slot that was presented at the previous rising clock edge. Corrupting a bit means fbit_o is the inverse of that slot's fbit_i.
- R3: While periodic_en_i stays high, candidates are counted starting from the one that follows the enable. Candidate number 128·k (k ≥ 1) is inverted, and the periodic control inverts no other bit.
- R4: Driving periodic_en_i low clears the candidate count. After periodic_en_i is raised again, the next periodic inversion falls on the 128th candidate counted from that point.
- R5: A rising edge of burst_ctl_i is found by comparing its value at a clock edge with its value at the previous edge. The edge causes the next three candidates that are presented at later edges to be inverted. A candidate presented at the same edge as the rising edge is not part of the burst.
- R6: Keeping burst_ctl_i high does not start a further burst. A new rising edge that arrives while a burst is still in progress restarts the burst with three candidates.
- R7: When a periodic inversion and a burst inversion fall on the same candidate, that bit is inverted once.
- R8: While rst_ni is low, fbit_o and fbit_valid_o are 0, the candidate count and the burst state are cleared, and the stored burst_ctl_i history is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esf_mode_i | input | 1 | Selects the candidate marker: 0 uses the 12-frame superframe marker, 1 uses the 24-frame extended superframe marker |
| fbit_i | input | 1 | Framing bit from the framer |
| fbit_valid_i | input | 1 | Marks a framing-bit slot |
| ft_slot_i | input | 1 | The slot carries a terminal-framing bit |
| fps_slot_i | input | 1 | The slot carries a frame-pattern-sequence bit |
| periodic_en_i | input | 1 | Held high to insert one error every 128 candidates |
| burst_ctl_i | input | 1 | A rising edge starts a burst of three errors |
| fbit_o | output | 1 | Framing bit, possibly inverted, one cycle after input |
| fbit_valid_o | output | 1 | fbit_valid_i delayed by one cycle |

## Verification
A candidate count that is wrong by even one shifts the periodic error to a different framing bit. Because the bench checks the position of every inversion, such an error is reported at the first expected hit, at most 128 candidates after the periodic control is enabled. A burst counter that loads, decrements or reloads wrongly changes the number of inverted bits within the next three candidates. Candidate selection that uses the wrong marker inverts a bit that should pass unchanged, and this is visible at fbit_o one cycle later. Phases that place a rising edge on a gap slot and that make the two error sources meet on one bit bring out the edge-timing and coincidence rules.

// File: rtl/t1_fbit_pkg.sv
package t1_fbit_pkg;
  typedef enum logic {
    FMT_SF  = 1'b0,
    FMT_ESF = 1'b1
  } fmt_e;

  localparam int unsigned DEF_PERIOD    = 128;
  localparam int unsigned DEF_BURST_LEN = 3;
endpackage

// File: rtl/t1_fbit_cand_sel.sv
module t1_fbit_cand_sel
  import t1_fbit_pkg::*;
(
  input  fmt_e fmt_i,
  input  logic valid_i,
  input  logic ft_slot_i,
  input  logic fps_slot_i,
  output logic cand_o
);
  always_comb begin
    unique case (fmt_i)
      FMT_SF:  cand_o = valid_i & ft_slot_i;
      FMT_ESF: cand_o = valid_i & fps_slot_i;
      default: cand_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/t1_fbit_periodic.sv
module t1_fbit_periodic #(
  parameter int unsigned PERIOD = 128,
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cand_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  generate
    if ((PERIOD & (PERIOD - 1)) == 0) begin : g_pow2
      // natural wrap
      assign at_last = &cnt_q;
    end else begin : g_cmp
      assign at_last = (cnt_q == LAST);
    end
  endgenerate

  assign hit_o = en_i & cand_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)        cnt_d = '0;
    else if (cand_i)  cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/t1_fbit_burst.sv
module t1_fbit_burst #(
  parameter int unsigned BURST_LEN = 3,
  localparam int unsigned LEFT_W = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_i,
  input  logic              cand_i,
  output logic              hit_o,
  output logic              prev_o,
  output logic [LEFT_W-1:0] left_o
);
  logic              prev_q;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              rise;

  assign rise  = ctl_i & ~prev_q;
  // the edge slot itself is excluded from the burst
  assign hit_o = cand_i & ~rise & (left_q != '0);

  always_comb begin
    left_d = left_q;
    if (rise)       left_d = LEFT_W'(BURST_LEN);
    else if (hit_o) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      left_q <= '0;
    end else begin
      prev_q <= ctl_i;
      left_q <= left_d;
    end
  end

  assign prev_o = prev_q;
  assign left_o = left_q;
endmodule

// File: rtl/t1_fbit_corruptor.sv
module t1_fbit_corruptor
  import t1_fbit_pkg::*;
#(
  parameter int unsigned PERIOD    = DEF_PERIOD,
  parameter int unsigned BURST_LEN = DEF_BURST_LEN,
  localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int unsigned LEFT_W = $clog2(BURST_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic esf_mode_i,
  input  logic fbit_i,
  input  logic fbit_valid_i,
  input  logic ft_slot_i,
  input  logic fps_slot_i,
  input  logic periodic_en_i,
  input  logic burst_ctl_i,
  output logic fbit_o,
  output logic fbit_valid_o
);
  logic              cand;
  logic              per_hit, burst_hit;
  logic [CNT_W-1:0]  per_cnt;
  logic [LEFT_W-1:0] burst_left;
  logic              burst_prev;
  fmt_e              fmt;

  assign fmt = fmt_e'(esf_mode_i);

  t1_fbit_cand_sel u_sel (
    .fmt_i      (fmt),
    .valid_i    (fbit_valid_i),
    .ft_slot_i  (ft_slot_i),
    .fps_slot_i (fps_slot_i),
    .cand_o     (cand)
  );

  t1_fbit_periodic #(.PERIOD(PERIOD)) u_per (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (periodic_en_i),
    .cand_i (cand),
    .hit_o  (per_hit),
    .cnt_o  (per_cnt)
  );

  t1_fbit_burst #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (burst_ctl_i),
    .cand_i (cand),
    .hit_o  (burst_hit),
    .prev_o (burst_prev),
    .left_o (burst_left)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fbit_o       <= 1'b0;
      fbit_valid_o <= 1'b0;
    end else begin
      fbit_o       <= fbit_i ^ (per_hit | burst_hit);
      fbit_valid_o <= fbit_valid_i;
    end
  end
endmodule

// File: rtl/t1_fbit_corruptor_chk.sv
module t1_fbit_corruptor_chk #(
  parameter int unsigned PERIOD    = 128,
  parameter int unsigned BURST_LEN = 3,
  localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int unsigned LEFT_W = $clog2(BURST_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              esf_mode_i,
  input logic              fbit_i,
  input logic              fbit_valid_i,
  input logic              ft_slot_i,
  input logic              fps_slot_i,
  input logic              periodic_en_i,
  input logic              burst_ctl_i,
  input logic              fbit_o,
  input logic              fbit_valid_o,
  input logic [CNT_W-1:0]  per_cnt,
  input logic [LEFT_W-1:0] burst_left
);
  logic cand_in;
  assign cand_in = fbit_valid_i & (esf_mode_i ? fps_slot_i : ft_slot_i);

  a_r1_noncand_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cand_in |=> (fbit_o == $past(fbit_i)));

  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fbit_valid_o == $past(fbit_valid_i)));

  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(per_cnt) < PERIOD);

  a_r4_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !periodic_en_i |=> (per_cnt == '0));

  a_r5_burst_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_ctl_i) |=> (32'(burst_left) == BURST_LEN));

  a_r6_no_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_ctl_i && $past(burst_ctl_i) && burst_left == '0) |=> (burst_left == '0));

  a_r6_left_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(burst_left) <= BURST_LEN);
endmodule

bind t1_fbit_corruptor t1_fbit_corruptor_chk #(
  .PERIOD    (PERIOD),
  .BURST_LEN (BURST_LEN)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .esf_mode_i    (esf_mode_i),
  .fbit_i        (fbit_i),
  .fbit_valid_i  (fbit_valid_i),
  .ft_slot_i     (ft_slot_i),
  .fps_slot_i    (fps_slot_i),
  .periodic_en_i (periodic_en_i),
  .burst_ctl_i   (burst_ctl_i),
  .fbit_o        (fbit_o),
  .fbit_valid_o  (fbit_valid_o),
  .per_cnt       (per_cnt),
  .burst_left    (burst_left)
);

// File: tb/t1_fbit_corruptor_tb_top.sv
module t1_fbit_corruptor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esf_mode = 1'b0, fbit = 1'b0, fvalid = 1'b0, ft = 1'b0, fps = 1'b0;
  logic per_en = 1'b0, burst = 1'b0;
  logic fbit_out, fvalid_out;

  int checks = 0, fails = 0, inv_cnt = 0, fc = 0;
  int m_pcnt = 0, m_brem = 0;
  bit m_prev = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  t1_fbit_corruptor dut_i (
    .clk_i (clk), .rst_ni (rst_n), .esf_mode_i (esf_mode),
    .fbit_i (fbit), .fbit_valid_i (fvalid), .ft_slot_i (ft), .fps_slot_i (fps),
    .periodic_en_i (per_en), .burst_ctl_i (burst),
    .fbit_o (fbit_out), .fbit_valid_o (fvalid_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one slot: drive at negedge, model, check at next negedge
  task automatic slot(input bit v, input bit f_t, input bit f_ps, input bit b, input string tag);
    bit cand, rise, ph, bh, e;
    fvalid = v; ft = f_t; fps = f_ps; fbit = b;
    cand = v && (esf_mode ? f_ps : f_t);
    rise = burst && !m_prev;
    ph   = per_en && cand && (m_pcnt == 127);
    bh   = cand && !rise && (m_brem > 0);
    e    = b ^ (ph | bh);
    if (!per_en) m_pcnt = 0;
    else if (cand) m_pcnt = (m_pcnt == 127) ? 0 : m_pcnt + 1;
    if (rise) m_brem = 3;
    else if (bh) m_brem--;
    m_prev = burst;
    @(negedge clk);
    check(fvalid_out == v, {tag, " valid"}, fvalid_out, v);
    check(fbit_out == e, {tag, " fbit"}, fbit_out, e);
    if (fbit_out != b) inv_cnt++;
  endtask

  // framing slots over a 24-frame cycle, gap before every fourth frame
  task automatic frames(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (fc % 4 == 2) slot(1'b0, 1'b0, 1'b0, 1'b0, tag);
      slot(1'b1, (fc % 2) == 0, (fc % 4) == 3, ((fc * 5) >> 1) & 1, tag);
      fc = (fc + 1) % 24;
    end
  endtask

  task automatic expect_inv(input int exp, input string tag);
    check(inv_cnt == exp, {tag, " inversion count"}, inv_cnt, exp);
    inv_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fbit_out == 1'b0, "R8 reset fbit", fbit_out, 0);
    check(fvalid_out == 1'b0, "R8 reset valid", fvalid_out, 0);
    rst_n = 1'b1;

    // R1: no controls, both modes, wrong-mode markers pass
    esf_mode = 1'b0; frames(48, "R1 sf idle");  expect_inv(0, "R1");
    esf_mode = 1'b1; frames(48, "R1 esf idle"); expect_inv(0, "R1");

    // R3: periodic, sf: 512 frames -> 256 candidates
    esf_mode = 1'b0; fc = 0; per_en = 1'b1;
    frames(512, "R3 sf periodic"); expect_inv(2, "R3 sf");
    per_en = 1'b0; frames(2, "R3 off");

    // R3: periodic, esf: 512 frames -> 128 candidates
    esf_mode = 1'b1; fc = 0; per_en = 1'b1;
    frames(512, "R3 esf periodic"); expect_inv(1, "R3 esf");
    per_en = 1'b0; frames(2, "R4 off");

    // R4: disable mid-count clears it
    esf_mode = 1'b0; fc = 0; per_en = 1'b1;
    frames(200, "R4 first"); per_en = 1'b0; frames(2, "R4 gap");
    per_en = 1'b1; frames(254, "R4 restart"); expect_inv(0, "R4 before 128th");
    frames(2, "R4 hit"); expect_inv(1, "R4 128th");
    per_en = 1'b0; frames(2, "R4 off");

    // R5/R6: burst in sf mode
    burst = 1'b1; frames(20, "R5 burst"); expect_inv(3, "R5 sf burst");
    frames(40, "R6 held"); expect_inv(0, "R6 held high");
    burst = 1'b0; frames(2, "R6 low");
    burst = 1'b1; frames(20, "R5 second"); expect_inv(3, "R5 second burst");
    burst = 1'b0; frames(2, "R6 low");

    // R5: rise on a candidate slot does not count it
    fc = 0; burst = 1'b1;
    slot(1'b1, 1'b1, 1'b0, 1'b0, "R5 edge slot"); fc = 1;
    expect_inv(0, "R5 edge slot excluded");
    frames(20, "R5 after edge"); expect_inv(3, "R5 after edge");
    burst = 1'b0; frames(2, "R6 low");

    // R6: retrigger mid-burst restarts at three
    fc = 0; burst = 1'b1; slot(1'b0, 1'b0, 1'b0, 1'b0, "R6 rise");
    frames(2, "R6 partial");
    burst = 1'b0; slot(1'b0, 1'b0, 1'b0, 1'b0, "R6 drop");
    burst = 1'b1; slot(1'b0, 1'b0, 1'b0, 1'b0, "R6 re-rise");
    frames(20, "R6 retrig"); expect_inv(4, "R6 retrigger");
    burst = 1'b0; frames(2, "R6 low");

    // R5: burst in esf mode touches only fps slots
    esf_mode = 1'b1; burst = 1'b1; frames(24, "R5 esf burst"); expect_inv(3, "R5 esf burst");
    burst = 1'b0; frames(2, "R5 low");

    // R7: periodic hit and burst on the same candidate
    esf_mode = 1'b0; fc = 0; per_en = 1'b1;
    frames(254, "R7 pre"); expect_inv(0, "R7 pre");
    burst = 1'b1; slot(1'b0, 1'b0, 1'b0, 1'b0, "R7 rise");
    frames(6, "R7 overlap"); expect_inv(3, "R7 single inversion");
    burst = 1'b0; per_en = 1'b0; frames(4, "R7 tail");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule